// File: doc/BRIEF.md
# Scalar Bit Walker

This block steps through the bits of a scalar one at a time, as needed by the control loop of an exponentiation-by-squaring or double-and-add engine. A start pulse loads the scalar and an ordering choice. From the next cycle on, the block presents one bit per step to the arithmetic datapath that follows it. That datapath accepts each bit with an advance input, so it may spend as many cycles on a bit as it needs.

In most-significant-first order, leading zeros are never walked. A combinational leading-one detector finds the top set bit while the scalar is loaded. The working register is pre-shifted so that the bit of interest always sits at one fixed position. A one-hot marker is loaded at the top-bit index and moves down one place per step. When the marker reaches position 0, the final step has come.

In least-significant-first order, the working register shifts right on every step. The walk ends when the bits still to be presented are all zero, which is found by OR-reducing them. In both orders the number of steps equals the significant length of the scalar. A zero scalar gives no steps at all and completes immediately.

Top module: `scalar_bit_walker`

## Requirements
- R1: With the scalar 17 in most-significant-first mode (`lsb_first_i`=0), exactly 5 steps are offered, with bits 1,0,0,0,1 in that order.
- R2: For a nonzero scalar, `valid_o` is high in the cycle after the start pulse is sampled, with no cycles spent on leading zeros. In most-significant-first mode the first bit is 1.
- R3: The number of steps offered equals the index of the highest set bit plus one, in either mode.
- R4: With `lsb_first_i`=1, bits are presented from bit 0 upward, and the last step is the highest set bit.
- R5: A zero scalar offers no step: `done_o` is high in the cycle after the start pulse and `valid_o` stays low.
- R6: `last_o` is high only together with `valid_o`, and only on the final step.
- R7: `done_o` is high for exactly one cycle, the cycle after the final step is accepted (`valid_o` and `step_ack_i` both high).
- R8: While `valid_o` is high and `step_ack_i` is low, `valid_o`, `bit_o` and `last_o` hold their values.
- R9: A start pulse that arrives while a walk is in progress is ignored, and the walk in progress continues unchanged.
- R10: The ordering input is sampled only with an accepted start pulse. Changing it during a walk has no effect.
- R11: After reset, `valid_o`, `last_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; loads the scalar and the order when idle |
| scalar_i | input | W | Scalar to walk |
| lsb_first_i | input | 1 | 0 = most significant bit first, 1 = least significant bit first |
| step_ack_i | input | 1 | Datapath accepts the current bit |
| bit_o | output | 1 | Current scalar bit |
| valid_o | output | 1 | A step is being offered |
| last_o | output | 1 | The current step is the final one |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two situations are hard to bring about from the ports. The first is a start pulse or an ordering change that lands in the middle of a walk, while the datapath is stalling. The driver reaches it by pulsing start with a different scalar and by flipping the ordering input partway through a slow, stalled acknowledgement pattern. The second is the set of boundary scalars: zero, one, a single top bit, all ones, and a top bit with trailing zeros. In most-significant-first mode these decide whether the end marker, rather than the remaining data, ends the walk. Each one is run in both orders with and without stalls.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic {
    DIR_MSB_FIRST = 1'b0,
    DIR_LSB_FIRST = 1'b1
  } walk_dir_e;
endpackage

// File: rtl/lead_one_detect.sv
// Combinational priority structure: index of the highest set bit.
module lead_one_detect #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bit_shifter.sv
// Working register: the bit of interest always sits at a fixed end.
module bit_shifter
  import sbw_pkg::*;
#(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [W-1:0]  value_i,
  input  logic [IW-1:0] align_i,
  input  walk_dir_e     dir_i,
  input  logic          shift_i,
  output logic          cur_bit_o,
  output logic          rest_zero_o
);
  logic [W-1:0]  work_q;
  walk_dir_e     dir_q;
  logic [IW-1:0] lshamt;

  assign lshamt = IW'(W - 1) - align_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      dir_q  <= DIR_MSB_FIRST;
    end else if (load_i) begin
      dir_q  <= dir_i;
      work_q <= (dir_i == DIR_LSB_FIRST) ? value_i : (value_i << lshamt);
    end else if (shift_i) begin
      work_q <= (dir_q == DIR_LSB_FIRST) ? (work_q >> 1) : (work_q << 1);
    end
  end

  assign cur_bit_o   = (dir_q == DIR_LSB_FIRST) ? work_q[0] : work_q[W-1];
  assign rest_zero_o = (dir_q == DIR_LSB_FIRST) ? ~|work_q[W-1:1] : ~|work_q[W-2:0];
endmodule

// File: rtl/end_marker.sv
// Loadable one-hot shift register marking the final step.
module end_marker #(
  parameter int W  = 32,
  localparam int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          arm_i,
  input  logic [IW-1:0] pos_i,
  input  logic          shift_i,
  output logic          tail_o
);
  logic [W-1:0] mark_q;

  always_ff @(posedge clk) begin
    if (rst)          mark_q <= '0;
    else if (load_i)  mark_q <= arm_i ? ({{(W-1){1'b0}}, 1'b1} << pos_i) : '0;
    else if (shift_i) mark_q <= mark_q >> 1;
  end

  assign tail_o = mark_q[0];

  a_r3_marker_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mark_q));
  a_r3_marker_moves: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i && !mark_q[0] && mark_q != '0) |=> (mark_q != '0));
endmodule

// File: rtl/scalar_bit_walker.sv
module scalar_bit_walker
  import sbw_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [W-1:0] scalar_i,
  input  logic         lsb_first_i,
  input  logic         step_ack_i,
  output logic         bit_o,
  output logic         valid_o,
  output logic         last_o,
  output logic         done_o
);
  localparam int IW = $clog2(W);

  logic [IW-1:0] top_idx;
  logic          nonzero;
  logic          busy_q, done_q;
  walk_dir_e     dir_q;
  logic          take, accept;
  logic          cur_bit, rest_zero, tail;
  walk_dir_e     dir_in;

  assign dir_in = walk_dir_e'(lsb_first_i);
  assign take   = start_i & ~busy_q;
  assign accept = busy_q & step_ack_i;

  lead_one_detect #(.W(W)) u_lod (
    .vec_i (scalar_i),
    .idx_o (top_idx),
    .any_o (nonzero)
  );

  bit_shifter #(.W(W)) u_shf (
    .clk         (clk),
    .rst         (rst),
    .load_i      (take),
    .value_i     (scalar_i),
    .align_i     (top_idx),
    .dir_i       (dir_in),
    .shift_i     (accept),
    .cur_bit_o   (cur_bit),
    .rest_zero_o (rest_zero)
  );

  end_marker #(.W(W)) u_mark (
    .clk    (clk),
    .rst    (rst),
    .load_i (take),
    .arm_i  (nonzero && dir_in == DIR_MSB_FIRST),
    .pos_i  (top_idx),
    .shift_i(accept),
    .tail_o (tail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      dir_q  <= DIR_MSB_FIRST;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        dir_q <= dir_in;
        if (nonzero) busy_q <= 1'b1;
        else         done_q <= 1'b1;
      end else if (accept && last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign valid_o = busy_q;
  assign bit_o   = busy_q & cur_bit;
  assign last_o  = busy_q & ((dir_q == DIR_LSB_FIRST) ? rest_zero : tail);
  assign done_o  = done_q;

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !step_ack_i) |=> (valid_o && $stable(bit_o) && $stable(last_o)));
  a_r7_done_after_final: assert property (@(posedge clk) disable iff (rst)
    (valid_o && step_ack_i && last_o) |=> (done_o && !valid_o));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (valid_o && start_i && !(step_ack_i && last_o)) |=> valid_o);
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(done_o && valid_o));
  a_r2_first_is_one: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid_o) && dir_q == DIR_MSB_FIRST) |-> bit_o);
endmodule

// File: tb/scalar_bit_walker_bench.sv
module scalar_bit_walker_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] scalar_i = '0;
  logic         lsb_first_i = 1'b0;
  logic         step_ack_i = 1'b0;
  logic         bit_o, valid_o, last_o, done_o;

  int checks = 0;
  int fails  = 0;
  int stall  = 0;
  int ackcnt = 0;
  logic [1:0] expq[$];
  int pops = 0;

  always #10 clk = ~clk;

  scalar_bit_walker #(.W(W)) u_scalar_bit_walker (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // acknowledge generator: stall = number of idle cycles between acks
  always @(posedge clk) begin
    #1;
    ackcnt++;
    step_ack_i <= (stall == 0) ? 1'b1 : ((ackcnt % (stall + 1)) == 0);
  end

  // monitor: pop expected steps as they are accepted
  logic prev_stalled = 1'b0;
  logic prev_bit = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stalled)
        check(valid_o && bit_o == prev_bit, "R8 hold", int'(bit_o), int'(prev_bit));
      prev_stalled = valid_o && !step_ack_i;
      prev_bit = bit_o;
      check(!last_o || valid_o, "R6 last without valid", int'(last_o), 0);
      if (valid_o && step_ack_i) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3 extra step", pops + 1, pops);
        end else begin
          logic [1:0] e;
          e = expq.pop_front();
          pops++;
          check(bit_o == e[1], "R1/R4 bit", int'(bit_o), int'(e[1]));
          check(last_o == e[0], "R6 last", int'(last_o), int'(e[0]));
        end
      end
    end
  end

  task automatic walk(input logic [W-1:0] s, input bit lsb, input int st, input bit disturb);
    int p;
    int n;
    p = -1;
    for (int i = 0; i < W; i++) if (s[i]) p = i;
    if (lsb) for (int i = 0; i <= p; i++) expq.push_back({s[i], 1'(i == p)});
    else     for (int i = p; i >= 0; i--) expq.push_back({s[i], 1'(i == 0)});
    stall = st;
    pops = 0;
    @(posedge clk); #2;
    start_i = 1'b1; scalar_i = s; lsb_first_i = lsb;
    @(posedge clk); #2;
    start_i = 1'b0;
    @(negedge clk);
    if (p < 0) begin
      check(done_o && !valid_o, "R5 zero scalar", int'(done_o), 1);
    end else begin
      check(valid_o && !done_o, "R2 valid next cycle", int'(valid_o), 1);
      if (!lsb) check(bit_o, "R2 first bit is one", int'(bit_o), 1);
    end
    if (disturb && p > 1) begin
      // R9: start while busy; R10: order change mid-walk
      @(posedge clk); #2;
      start_i = 1'b1; scalar_i = 32'h0000_0003; lsb_first_i = ~lsb;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(done_o, "R7 done seen", int'(done_o), 1);
    check(expq.size() == 0 && pops == p + 1, "R3 step count", pops, p + 1);
    expq.delete();
    @(negedge clk);
    check(!done_o && !valid_o, "R7 done one cycle / R9 no restart", int'(done_o), 0);
    lsb_first_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    check(!valid_o && !last_o && !done_o, "R11 reset", int'({valid_o, last_o, done_o}), 0);
    walk(32'd17, 1'b0, 0, 1'b0);          // R1
    walk(32'd17, 1'b0, 2, 1'b0);          // R1 with stalls
    walk(32'd17, 1'b1, 0, 1'b0);          // R4
    walk(32'd0, 1'b0, 0, 1'b0);           // R5
    walk(32'd0, 1'b1, 1, 1'b0);           // R5
    walk(32'd1, 1'b0, 0, 1'b0);
    walk(32'd1, 1'b1, 3, 1'b0);
    walk(32'h8000_0000, 1'b0, 1, 1'b0);
    walk(32'h8000_0000, 1'b1, 0, 1'b0);
    walk(32'hFFFF_FFFF, 1'b0, 0, 1'b0);
    walk(32'hFFFF_FFFF, 1'b1, 1, 1'b0);
    walk(32'h0001_0000, 1'b0, 0, 1'b0);
    walk(32'h00A5_3C00, 1'b1, 2, 1'b0);
    walk(32'h00A5_3C00, 1'b0, 3, 1'b1);   // R9, R10
    walk(32'h0000_0F10, 1'b1, 3, 1'b1);   // R9, R10
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule